// File: doc/BRIEF.md
# Bit Rotate-Exchange Datapath

This block is the combinational core of a rotate-with-exchange operation on a 32-bit operand. It takes a source word, a primary shift amount, an alternate shift amount and a stripe flag, and returns a 64-bit result whose upper half is a copy of bit 31 of the 32-bit outcome. When both amounts are the same and the stripe flag is low, the operation is a plain rotate right. When the amounts differ, different bit positions rotate by different distances, so groups of bits are exchanged with one another.

Internally, the source is copied into both halves of a 64-bit working value. That value then passes through five conditional move stages of 16, 8, 4, 2 and 1 positions. At each stage, bits of the position's own index decide which of the two amounts governs that position. One bit of the chosen amount then decides whether the position takes the bit that lies that many places above it or keeps its current value.

The block has no clock and no storage. It sits between operand fetch and result write-back, and that surrounding logic supplies any registering and flow control. The stream handshake of the house style does not apply, because no data is buffered here.

Top module: `xrot_unit`

## Requirements
- R1: When `stripe_i` is 0 and `shift_i` equals `shift_alt_i`, `result_o[31:0]` is `src_i` rotated right by `shift_i` places.
- R2: In the 16-place stage, a position whose index bit 3 is 1 is governed by `shift_i`, and any other position is governed by `shift_alt_i`. The position takes the bit 16 places above it when bit 4 of the governing amount is 1. Example: src 0x0000FFFF, shift 0, alternate 16 gives 0x00FFFF00.
- R3: With `stripe_i` at 1, the 16-place stage inverts the governing amount for positions whose index bit 2 is 0. The later stages never apply this inversion. Example: src 0x0000FFFF, both amounts 0, stripe 1 gives 0x0F0FF0F0.
- R4: The 8-, 4- and 2-place stages choose the governing amount by index bit 2, 1 and 0 respectively, where 1 selects `shift_i`. They test bit 3, 2 and 1 of that amount respectively.
- R5: The 1-place stage always uses `shift_i` and tests its bit 0. Bit 0 of `shift_alt_i` never affects the result.
- R6: A position whose control bit is 0 keeps its value from the previous stage. With both amounts 0 and stripe 0, `result_o[31:0]` equals `src_i`.
- R7: `result_o[63:32]` is a copy of `result_o[31]` in every bit.
- R8: Every result bit is taken from some source bit. An all-zero source gives an all-zero result, and an all-one source gives an all-one result, for any amounts and any stripe value.
- R9: The output follows a change on any input with no clock edge and no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Source operand |
| shift_i | input | 5 | Primary shift amount |
| shift_alt_i | input | 5 | Alternate shift amount |
| stripe_i | input | 1 | Stripe flag; inverts the first-stage amount on positions with index bit 2 clear |
| result_o | output | 64 | Low 32 bits of the outcome, sign-extended |

## Verification
Operands with equal amounts and no stripe are checked against a plain right rotate, which confirms the duplication and the stage order. Operands such as 0x0000FFFF, 0x000000FF and 0x0000000F are paired with one nonzero amount bit at a time, and the placement of the set bits shows which index bit chose between the amounts at that stage and whether the stripe inversion reached it. Sweeping every amount pair with both stripe values over random operands, compared with a bit-level model, separates any swapped select bit or tested amount bit. All-zero and all-one operands confirm that no constant leaks into the result.

// File: rtl/xrot_pkg.sv
package xrot_pkg;

  // Highest working-vector position a stage must produce so that the
  // stages after it still have every bit they read.
  function automatic int stage_last(input int data_w, input int log_d);
    return data_w - 1 + (1 << log_d) - 1;
  endfunction

  // Stage order runs from the widest move to the narrowest.
  function automatic int stage_log(input int sh_w, input int idx);
    return sh_w - 1 - idx;
  endfunction

endpackage

// File: rtl/xrot_stage.sv
module xrot_stage #(
  parameter int DATA_W    = 32,
  parameter int SH_W      = 5,
  parameter int LOG_D     = 4,
  parameter bit STRIPE_EN = 1'b0
) (
  input  logic [2*DATA_W-1:0] din,
  input  logic [SH_W-1:0]     amt_pri,
  input  logic [SH_W-1:0]     amt_alt,
  input  logic                stripe,
  output logic [2*DATA_W-1:0] dout
);
  localparam int WORK_W = 2 * DATA_W;
  localparam int DIST   = 1 << LOG_D;
  localparam int LAST   = xrot_pkg::stage_last(DATA_W, LOG_D);

  logic unused_in;
  assign unused_in = ^{amt_pri, amt_alt, stripe};

  for (genvar i = 0; i < WORK_W; i++) begin : gen_pos
    if (i > LAST) begin : g_pass
      assign dout[i] = din[i];
    end else begin : g_move
      logic base_bit;
      logic flip;
      logic ctl;

      // Choose which amount governs this position.
      if (LOG_D == 0) begin : g_pri_only
        assign base_bit = amt_pri[LOG_D];
      end else begin : g_pick
        if (((i >> (LOG_D - 1)) & 1) == 1) begin : g_pri
          assign base_bit = amt_pri[LOG_D];
        end else begin : g_alt
          assign base_bit = amt_alt[LOG_D];
        end
      end

      // Stripe inversion of the chosen amount.
      if (STRIPE_EN && LOG_D >= 2) begin : g_stripe
        if (((i >> (LOG_D - 2)) & 1) == 0) begin : g_inv
          assign flip = stripe;
        end else begin : g_noinv
          assign flip = 1'b0;
        end
      end else begin : g_nostripe
        assign flip = 1'b0;
      end

      assign ctl     = base_bit ^ flip;
      assign dout[i] = ctl ? din[i + DIST] : din[i];
    end
  end
endmodule

// File: rtl/xrot_extend.sv
module xrot_extend #(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 64
) (
  input  logic [DATA_W-1:0] low,
  output logic [OUT_W-1:0]  wide
);
  localparam int EXT_W = OUT_W - DATA_W;

  assign wide = {{EXT_W{low[DATA_W-1]}}, low};
endmodule

// File: rtl/xrot_unit.sv
module xrot_unit #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5,
  parameter int OUT_W  = 64
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [SH_W-1:0]   shift_alt_i,
  input  logic              stripe_i,
  output logic [OUT_W-1:0]  result_o
);
  localparam int WORK_W = 2 * DATA_W;
  localparam int NSTG   = SH_W;

  logic [WORK_W-1:0] work [NSTG+1];

  assign work[0] = {src_i, src_i};

  for (genvar g = 0; g < NSTG; g++) begin : gen_stage
    xrot_stage #(
      .DATA_W   (DATA_W),
      .SH_W     (SH_W),
      .LOG_D    (xrot_pkg::stage_log(SH_W, g)),
      .STRIPE_EN(g == 0)
    ) u_stage (
      .din    (work[g]),
      .amt_pri(shift_i),
      .amt_alt(shift_alt_i),
      .stripe (stripe_i),
      .dout   (work[g+1])
    );
  end

  logic unused_hi;
  assign unused_hi = ^work[NSTG][WORK_W-1:DATA_W];

  xrot_extend #(
    .DATA_W(DATA_W),
    .OUT_W (OUT_W)
  ) u_extend (
    .low (work[NSTG][DATA_W-1:0]),
    .wide(result_o)
  );

  // Checks on the finished result against properties of the inputs.
  logic [DATA_W-1:0] ror_ref;

  always_comb begin
    ror_ref = DATA_W'({src_i, src_i} >> shift_i);

    if (!stripe_i && shift_i == shift_alt_i) begin
      p_uniform_rot_r1: assert (result_o[DATA_W-1:0] == ror_ref)
        else $error("R1 uniform amounts did not rotate");
    end

    if (!stripe_i && shift_i == '0 && shift_alt_i == '0) begin
      p_identity_r6: assert (result_o[DATA_W-1:0] == src_i)
        else $error("R6 zero amounts changed the operand");
    end

    p_sext_r7: assert (result_o[OUT_W-1:DATA_W] == {(OUT_W-DATA_W){result_o[DATA_W-1]}})
      else $error("R7 upper half is not a copy of the sign bit");

    if (src_i == '0) begin
      p_zero_src_r8: assert (result_o == '0)
        else $error("R8 zero operand produced set bits");
    end

    if (src_i == '1) begin
      p_ones_src_r8: assert (result_o == '1)
        else $error("R8 all-one operand produced clear bits");
    end
  end
endmodule

// File: tb/tb_xrot_unit.sv
`timescale 1ns/1ps
module tb_xrot_unit;
  localparam int DATA_W = 32;
  localparam int SH_W   = 5;
  localparam int OUT_W  = 64;
  localparam int VEC_W  = DATA_W + 2*SH_W + 1 + OUT_W;
  localparam int NVEC   = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [DATA_W-1:0] src;
  logic [SH_W-1:0]   sh;
  logic [SH_W-1:0]   alt;
  logic              stp;
  logic [OUT_W-1:0]  res;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  xrot_unit dut (
    .src_i      (src),
    .shift_i    (sh),
    .shift_alt_i(alt),
    .stripe_i   (stp),
    .result_o   (res)
  );

  // {source, primary, alternate, stripe, expected}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {32'h12345678, 5'd0,  5'd0,  1'b0, 64'h0000000012345678}, // R6
    {32'h12345678, 5'd4,  5'd4,  1'b0, 64'hFFFFFFFF81234567}, // R1
    {32'h12345678, 5'd8,  5'd8,  1'b0, 64'h0000000078123456}, // R1
    {32'h80000001, 5'd1,  5'd1,  1'b0, 64'hFFFFFFFFC0000000}, // R1 R7
    {32'h00000001, 5'd31, 5'd31, 1'b0, 64'h0000000000000002}, // R1
    {32'hDEADBEEF, 5'd16, 5'd16, 1'b0, 64'hFFFFFFFFBEEFDEAD}, // R1
    {32'h0000FFFF, 5'd0,  5'd0,  1'b1, 64'h000000000F0FF0F0}, // R3
    {32'h0000FFFF, 5'd0,  5'd16, 1'b0, 64'h0000000000FFFF00}, // R2
    {32'h0000FFFF, 5'd16, 5'd0,  1'b0, 64'hFFFFFFFFFF0000FF}, // R2 R7
    {32'h000000FF, 5'd0,  5'd8,  1'b0, 64'h000000000F0000F0}, // R4
    {32'h0000000F, 5'd0,  5'd4,  1'b0, 64'h000000003000000C}, // R4
    {32'h00000001, 5'd0,  5'd2,  1'b0, 64'h0000000040000000}, // R4
    {32'h00000003, 5'd1,  5'd0,  1'b0, 64'hFFFFFFFF80000001}, // R5
    {32'h00000003, 5'd0,  5'd1,  1'b0, 64'h0000000000000003}, // R5
    {32'h00000000, 5'd21, 5'd10, 1'b1, 64'h0000000000000000}  // R8
  };

  // Bit-level model written from the requirements.
  function automatic logic [OUT_W-1:0] model(input logic [31:0] s, input logic [4:0] p,
                                             input logic [4:0] a, input logic st);
    logic [63:0] cur;
    logic [63:0] nxt;
    cur = {s, s};
    for (int k = 4; k >= 0; k--) begin
      int d;
      d = 1 << k;
      nxt = cur;
      for (int i = 0; i <= 31 + d - 1; i++) begin
        logic [4:0] amt;
        if (k == 0) amt = p;
        else amt = ((i >> (k - 1)) & 1) != 0 ? p : a;
        if (k == 4 && st && ((i >> 2) & 1) == 0) amt = ~amt;
        if (amt[k]) nxt[i] = cur[i + d];
      end
      cur = nxt;
    end
    return {{32{cur[31]}}, cur[31:0]};
  endfunction

  task automatic check(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (src=%h sh=%0d alt=%0d stripe=%0b)",
               tag, act, exp, src, sh, alt, stp);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic [4:0] p, input logic [4:0] a, input logic st);
    @(posedge clk);
    #1;
    src = s; sh = p; alt = a; stp = st;
    #2;
  endtask

  initial begin
    src = '0; sh = '0; alt = '0; stp = 1'b0;
    #3;
    check("R8 initial zero inputs", res, 64'h0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [VEC_W-1:0] e;
      e = VEC[v];
      apply(e[VEC_W-1 -: 32], e[74:70], e[69:65], e[64]);
      check("R1-table vector", res, e[63:0]);
    end

    // R8 all-one operand with stripe
    apply(32'hFFFFFFFF, 5'd7, 5'd30, 1'b1);
    check("R8 all-one operand", res, {64{1'b1}});

    // R9 output moves between clock edges
    apply(32'h00000001, 5'd0, 5'd0, 1'b0);
    #1 src = 32'h80000000;
    #1 check("R9 combinational response", res, 64'hFFFFFFFF80000000);

    // R5 bit 0 of alternate has no effect
    apply(32'hA5C3F00F, 5'd6, 5'd9, 1'b1);
    begin
      logic [OUT_W-1:0] first;
      first = res;
      apply(32'hA5C3F00F, 5'd6, 5'd8, 1'b1);
      check("R5 alternate bit 0 ignored", res, first);
    end

    // Exhaustive amounts and stripe, random operands
    for (int p = 0; p < 32; p++) begin
      for (int a = 0; a < 32; a++) begin
        for (int st = 0; st < 2; st++) begin
          logic [31:0] r;
          r = $urandom;
          apply(r, 5'(p), 5'(a), 1'(st));
          check("R2 R3 R4 R5 R7 model sweep", res, model(r, 5'(p), 5'(a), 1'(st)));
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule